// File: doc/BRIEF.md
# Reference Clock Quality Monitor

This block judges whether one reference clock input is usable. The input arrives as a one-cycle edge strobe that has already been synchronised to the local system clock. Two checks run side by side, each on its own timescale. A fast activity check drops its flag after a short run of sampling ticks with no strobe. This lets a selected reference be disqualified after a few missing input cycles. A slow frequency check counts strobes over a programmable gate window and subtracts the expected count. The result is a signed offset. The offset goes through a hysteresis qualifier with separate reject and accept limits. When the expected count per gate is 5,000,000, one count of offset is 0.2 ppm.

The reference is valid when both checks pass. Any change of the valid flag raises a one-cycle strobe. A low-rate mode slows the sampling tick by a power of two, so that the timeout counter and the gate counter can span references as slow as 1 Hz. A system with four reference inputs places one instance per input, and each instance runs independently.

The activity check is a two-state machine. LOST moves to PRESENT on a strobe. PRESENT moves to LOST on a timeout. The frequency qualifier is a three-state machine. UNMEASURED moves to IN_RANGE or OUT_RANGE on the first measurement. IN_RANGE moves to OUT_RANGE when the magnitude exceeds the reject limit. OUT_RANGE moves to IN_RANGE when the magnitude falls below the accept limit.

Top module: `refclk_quality_mon`

## Requirements
- R1: While rst_n is low, activity_ok, freq_ok, ref_valid, valid_change and offset_valid are 0 and offset is 0.
- R2: A strobe sampled at a clock edge sets activity_ok from the next cycle on.
- R3: With act_limit = L and a tick every cycle, activity_ok falls at the (L+1)th consecutive sampling edge that carries no strobe.
- R4: Every gate_len ticks, offset becomes the two's-complement difference between the strobes counted in that window and expected_count. offset_valid pulses for exactly one cycle in the cycle after the window's last edge, and offset changes only then.
- R5: freq_ok stays 0 until the first measurement. That measurement sets freq_ok only if its magnitude is below accept_lim.
- R6: While freq_ok is 1, a measurement with magnitude at most reject_lim keeps it at 1. A magnitude above reject_lim clears it one cycle after offset_valid.
- R7: While freq_ok is 0, only a measurement with magnitude strictly below accept_lim sets it again. Magnitudes equal to accept_lim or above leave it at 0.
- R8: ref_valid is 1 exactly when activity_ok and freq_ok are both 1. valid_change is 1 in each cycle where ref_valid differs from its value in the previous cycle, and 0 otherwise.
- R9: With slow_mode at 1, both the timeout counter and the gate counter advance only once every 2^PRE_SHIFT cycles, while strobes are still counted on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_mode | input | 1 | Low-rate mode: sampling tick every 2^PRE_SHIFT cycles |
| edge_strobe | input | 1 | One-cycle pulse per reference edge, synchronised |
| act_limit | input | CNT_W | Ticks without a strobe tolerated before activity is lost |
| gate_len | input | GATE_W | Gate window length in ticks |
| expected_count | input | EDGE_W | Nominal strobe count per gate window |
| accept_lim | input | EDGE_W | Offset magnitude below which an out-of-range input is accepted |
| reject_lim | input | EDGE_W | Offset magnitude above which an in-range input is rejected |
| activity_ok | output | 1 | Strobes are arriving |
| freq_ok | output | 1 | Frequency offset within limits (with hysteresis) |
| ref_valid | output | 1 | activity_ok AND freq_ok |
| valid_change | output | 1 | One-cycle pulse on each change of ref_valid |
| offset | output | EDGE_W+1 | Signed measured offset, in strobe counts per gate |
| offset_valid | output | 1 | One-cycle pulse when offset is updated |

## Verification
Several properties are checked on every cycle. A strobe always sets activity, and a timeout always clears it. The offset changes only alongside offset_valid. The qualifier state moves only on a measurement and keeps its state inside the hysteresis band. Every edge of ref_valid carries a change strobe. Only the bench scenarios can show the offset arithmetic for real strobe patterns, the ordering of hysteresis decisions across a run of measurements, the exact cycle the timeout fires, and the slowdown in low-rate mode. The bench covers these with stepped input periods and directed loss-of-strobe runs.

// File: rtl/rcqm_pkg.sv
package rcqm_pkg;

    typedef enum logic {
        AS_LOST    = 1'b0,
        AS_PRESENT = 1'b1
    } act_state_t;

    typedef enum logic [1:0] {
        QS_UNMEASURED = 2'd0,
        QS_IN_RANGE   = 2'd1,
        QS_OUT_RANGE  = 2'd2
    } qual_state_t;

endpackage

// File: rtl/rcqm_tick.sv
module rcqm_tick #(
    parameter int PRE_SHIFT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_mode,
    output logic tick
);

    generate
        if (PRE_SHIFT == 0) begin : g_no_prescale
            assign tick = 1'b1;
        end else begin : g_prescale
            localparam logic [PRE_SHIFT-1:0] PRE_ONE = 1;
            logic [PRE_SHIFT-1:0] pre_cnt;

            always_ff @(posedge clk) begin
                if (!rst_n) pre_cnt <= '0;
                else        pre_cnt <= pre_cnt + PRE_ONE;
            end

            assign tick = slow_mode ? (&pre_cnt) : 1'b1;

            AST_SLOW_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                (slow_mode && tick) |=> (!tick || !slow_mode)); // R9
        end
    endgenerate

endmodule

// File: rtl/rcqm_activity.sv
module rcqm_activity
    import rcqm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             edge_strobe,
    input  logic [CNT_W-1:0] act_limit,
    output logic             activity_ok
);

    localparam logic [CNT_W-1:0] IDLE_MAX = '1;
    localparam logic [CNT_W-1:0] IDLE_ONE = 1;

    act_state_t       state_q, state_d;
    logic [CNT_W-1:0] idle_cnt;
    logic             timeout;

    // ticks elapsed since the last strobe, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                        idle_cnt <= '0;
        else if (edge_strobe)              idle_cnt <= '0;
        else if (tick && idle_cnt != IDLE_MAX) idle_cnt <= idle_cnt + IDLE_ONE;
    end

    assign timeout = tick && !edge_strobe && (idle_cnt >= act_limit);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AS_LOST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AS_LOST:    if (edge_strobe) state_d = AS_PRESENT;
            AS_PRESENT: if (timeout)     state_d = AS_LOST;
            default:    state_d = AS_LOST;
        endcase
    end

    always_comb begin
        activity_ok = (state_q == AS_PRESENT);
    end

    AST_STROBE_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        edge_strobe |=> activity_ok); // R2
    AST_TIMEOUT_CLEARS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !edge_strobe && idle_cnt >= act_limit) |=> !activity_ok); // R3

endmodule

// File: rtl/rcqm_freq_meter.sv
module rcqm_freq_meter #(
    parameter int GATE_W = 32,
    parameter int EDGE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              edge_strobe,
    input  logic [GATE_W-1:0] gate_len,
    input  logic [EDGE_W-1:0] expected_count,
    output logic [EDGE_W:0]   offset,
    output logic              offset_valid
);

    localparam int OFF_W = EDGE_W + 1;
    localparam logic [GATE_W:0]   G_ONE  = 1;
    localparam logic [GATE_W-1:0] G_INC  = 1;
    localparam logic [EDGE_W-1:0] E_ONE  = 1;
    localparam logic [EDGE_W-1:0] E_MAX  = '1;

    logic [GATE_W-1:0] gate_cnt;
    logic [EDGE_W-1:0] edge_cnt, edge_cnt_now;
    logic [OFF_W-1:0]  diff;
    logic              gate_last;

    assign gate_last    = tick && (({1'b0, gate_cnt} + G_ONE) >= {1'b0, gate_len});
    assign edge_cnt_now = (edge_strobe && edge_cnt != E_MAX) ? edge_cnt + E_ONE : edge_cnt;
    assign diff         = {1'b0, edge_cnt_now} - {1'b0, expected_count};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_cnt     <= '0;
            edge_cnt     <= '0;
            offset       <= '0;
            offset_valid <= 1'b0;
        end else begin
            offset_valid <= gate_last;
            if (gate_last) begin
                gate_cnt <= '0;
                edge_cnt <= '0;
                offset   <= diff;
            end else begin
                if (tick) gate_cnt <= gate_cnt + G_INC;
                edge_cnt <= edge_cnt_now;
            end
        end
    end

    AST_OFFSET_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(offset) |-> offset_valid); // R4
    AST_VALID_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_valid && gate_len > G_INC) |=> !offset_valid); // R4

endmodule

// File: rtl/rcqm_qualify.sv
module rcqm_qualify
    import rcqm_pkg::*;
#(
    parameter int EDGE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_valid,
    input  logic [EDGE_W:0]   offset,
    input  logic [EDGE_W-1:0] accept_lim,
    input  logic [EDGE_W-1:0] reject_lim,
    output logic              freq_ok
);

    localparam int OFF_W = EDGE_W + 1;
    localparam logic [OFF_W-1:0] O_ONE = 1;

    qual_state_t      state_q, state_d;
    logic [OFF_W-1:0] mag;
    logic             above_reject, below_accept;

    assign mag          = offset[OFF_W-1] ? (~offset + O_ONE) : offset;
    assign above_reject = mag > {1'b0, reject_lim};
    assign below_accept = mag < {1'b0, accept_lim};

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= QS_UNMEASURED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QS_UNMEASURED: if (meas_valid) state_d = below_accept ? QS_IN_RANGE : QS_OUT_RANGE;
            QS_IN_RANGE:   if (meas_valid && above_reject) state_d = QS_OUT_RANGE;
            QS_OUT_RANGE:  if (meas_valid && below_accept) state_d = QS_IN_RANGE;
            default:       state_d = QS_UNMEASURED;
        endcase
    end

    always_comb begin
        freq_ok = (state_q == QS_IN_RANGE);
    end

    AST_STATE_MOVES_ON_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |=> $stable(state_q)); // R6
    AST_NO_RETURN_UNMEASURED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != QS_UNMEASURED) |=> (state_q != QS_UNMEASURED)); // R5
    AST_IN_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_IN_RANGE && meas_valid && mag <= {1'b0, reject_lim})
            |=> (state_q == QS_IN_RANGE)); // R6
    AST_OUT_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_OUT_RANGE && meas_valid && mag >= {1'b0, accept_lim})
            |=> (state_q == QS_OUT_RANGE)); // R7

endmodule

// File: rtl/refclk_quality_mon.sv
module refclk_quality_mon #(
    parameter int CNT_W     = 16,
    parameter int GATE_W    = 32,
    parameter int EDGE_W    = 32,
    parameter int PRE_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_mode,
    input  logic              edge_strobe,
    input  logic [CNT_W-1:0]  act_limit,
    input  logic [GATE_W-1:0] gate_len,
    input  logic [EDGE_W-1:0] expected_count,
    input  logic [EDGE_W-1:0] accept_lim,
    input  logic [EDGE_W-1:0] reject_lim,
    output logic              activity_ok,
    output logic              freq_ok,
    output logic              ref_valid,
    output logic              valid_change,
    output logic [EDGE_W:0]   offset,
    output logic              offset_valid
);

    logic tick;
    logic valid_d;

    rcqm_tick #(.PRE_SHIFT(PRE_SHIFT)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_mode (slow_mode),
        .tick      (tick)
    );

    rcqm_activity #(.CNT_W(CNT_W)) u_activity (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .edge_strobe (edge_strobe),
        .act_limit   (act_limit),
        .activity_ok (activity_ok)
    );

    rcqm_freq_meter #(.GATE_W(GATE_W), .EDGE_W(EDGE_W)) u_meter (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .edge_strobe    (edge_strobe),
        .gate_len       (gate_len),
        .expected_count (expected_count),
        .offset         (offset),
        .offset_valid   (offset_valid)
    );

    rcqm_qualify #(.EDGE_W(EDGE_W)) u_qualify (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (offset_valid),
        .offset     (offset),
        .accept_lim (accept_lim),
        .reject_lim (reject_lim),
        .freq_ok    (freq_ok)
    );

    assign ref_valid = activity_ok & freq_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) valid_d <= 1'b0;
        else        valid_d <= ref_valid;
    end

    assign valid_change = ref_valid ^ valid_d;

    AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ref_valid) || $fell(ref_valid)) |-> valid_change); // R8

endmodule

// File: tb/sim_refclk_quality_mon.sv
module sim_refclk_quality_mon;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8, GATE_W = 10, EDGE_W = 8, PRE_SHIFT = 2;
    localparam int LIMIT = 40, GATE = 120, EXPECT = 12, ACCEPT = 3, REJECT = 5;
    localparam int NVEC = 10;
    localparam int VEC_PER [NVEC] = '{10, 12, 8, 6, 8, 12, 15, 20, 24, 10};
    localparam int VEC_OFF [NVEC] = '{ 0, -2, 3, 8, 3, -2, -4, -6, -7, 0};
    localparam int VEC_OK  [NVEC] = '{ 1,  1, 1, 0, 0,  1,  1,  0,  0, 1};

    logic clk = 1'b0;
    logic rst_n, slow_mode, edge_strobe;
    logic [CNT_W-1:0]  act_limit;
    logic [GATE_W-1:0] gate_len;
    logic [EDGE_W-1:0] expected_count, accept_lim, reject_lim;
    logic activity_ok, freq_ok, ref_valid, valid_change, offset_valid;
    logic [EDGE_W:0] offset;

    int errors = 0, checks = 0, per = 0, ph = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refclk_quality_mon #(.CNT_W(CNT_W), .GATE_W(GATE_W), .EDGE_W(EDGE_W), .PRE_SHIFT(PRE_SHIFT)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .edge_strobe(edge_strobe),
        .act_limit(act_limit), .gate_len(gate_len), .expected_count(expected_count),
        .accept_lim(accept_lim), .reject_lim(reject_lim), .activity_ok(activity_ok),
        .freq_ok(freq_ok), .ref_valid(ref_valid), .valid_change(valid_change),
        .offset(offset), .offset_valid(offset_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (per > 0) begin
            edge_strobe = (ph == 0);
            ph = (ph + 1 >= per) ? 0 : ph + 1;
        end else begin
            edge_strobe = 1'b0;
        end
    endtask

    task automatic restart(input int p);
        per = p;
        edge_strobe = 1'b1;
        ph = (p > 1) ? 1 : 0;
    endtask

    task automatic wait_meas();
        do cyc(); while (offset_valid !== 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; slow_mode = 1'b0; edge_strobe = 1'b0;
        act_limit = LIMIT; gate_len = GATE; expected_count = EXPECT;
        accept_lim = ACCEPT; reject_lim = REJECT;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 activity_ok", activity_ok, 0);
        check("R1 freq_ok", freq_ok, 0);
        check("R1 ref_valid", ref_valid, 0);
        check("R1 valid_change", valid_change, 0);
        check("R1 offset", int'($signed(offset)), 0);
        check("R1 offset_valid", offset_valid, 0);

        rst_n = 1'b1;
        restart(10);
        repeat (20) cyc();
        check("R2 activity after strobes", activity_ok, 1);
        check("R5 freq_ok before first gate", freq_ok, 0);
        check("R5 ref_valid before first gate", ref_valid, 0);

        // stepped period table: R4 offset, R6/R7 hysteresis, R8 change strobe
        for (int i = 0; i < NVEC; i++) begin
            wait_meas();
            restart(VEC_PER[i]);
            wait_meas();
            check("R4 offset", int'($signed(offset)), VEC_OFF[i]);
            cyc();
            check("R4 offset_valid single pulse", offset_valid, 0);
            check((VEC_OK[i] != 0) ? "R6 freq_ok" : "R7 freq_ok", freq_ok, VEC_OK[i]);
            check("R8 ref_valid", ref_valid, VEC_OK[i]);
            if (i > 0) check("R8 valid_change", valid_change, (VEC_OK[i] != VEC_OK[i-1]) ? 1 : 0);
        end

        // R3: fast timeout, one strobe then silence
        wait_meas();
        per = 0; edge_strobe = 1'b1;
        cyc();
        check("R2 activity after strobe", activity_ok, 1);
        repeat (LIMIT) cyc();
        check("R3 activity before timeout", activity_ok, 1);
        check("R8 ref_valid before timeout", ref_valid, 1);
        cyc();
        check("R3 activity after timeout", activity_ok, 0);
        check("R8 ref_valid after timeout", ref_valid, 0);
        check("R8 valid_change on loss", valid_change, 1);
        cyc();
        check("R8 valid_change one cycle", valid_change, 0);

        // R9: slow mode gate, 4*GATE cycles per window
        slow_mode = 1'b1;
        restart(48);
        wait_meas();
        restart(48);
        wait_meas();
        check("R9 slow gate offset", int'($signed(offset)), 4 * GATE / 48 - EXPECT);

        // R9: slow mode timeout
        per = 0; edge_strobe = 1'b1;
        cyc();
        repeat (4 * LIMIT) cyc();
        check("R9 slow activity held", activity_ok, 1);
        repeat (4) cyc();
        check("R9 slow activity lost", activity_ok, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule